// File: doc/BRIEF.md
# Byte to word packet packer

This block gathers a packetised stream of bytes into full-width words. Each incoming byte carries a valid flag and a flag that marks the final byte of its packet. The block drops bytes into successive byte lanes of an output word and emits the word once every lane is filled. It also emits the word early when the packet ends. The first byte of every packet always goes into the lowest lane, so packet starts are word aligned.

When a packet ends part way through a word, the unused upper lanes of that word are zero. The final word carries a last flag and a lane index that tells where the packet's final byte sits. From these a consumer can recover the exact byte length of the packet.

The output is a single register slot with a ready input. A new byte is refused while that slot holds a word that the consumer is not taking. Packets may follow each other with no idle cycle between them.

Top module: `byte_word_packer`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and `in_ready` is high.
- R2: The first byte of every packet appears in lane 0 (bits 7:0) of that packet's first output word.
- R3: Bytes of a packet fill lanes in ascending order, with lane k in bits 8k+7:8k. A word is emitted after its fourth byte is accepted, in the cycle following that acceptance.
- R4: In the final word of a packet, every lane above the lane of the last byte is zero.
- R5: The final word of a packet has `out_last` high and `out_end_lane` equal to the lane index (0 to 3) of the last byte, so a full final word reports 3. Every other word has `out_last` low and `out_end_lane` equal to 0.
- R6: A one-byte packet yields exactly one word, with the byte in lane 0, lanes 1 to 3 zero, `out_last` high and `out_end_lane` equal to 0.
- R7: A packet that starts in the cycle right after the previous packet's last byte is still aligned to lane 0 and loses no byte.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `out_end_lane` hold their values.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. Every byte presented while `in_ready` is high is accepted, and none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its packet |
| in_ready | output | 1 | Block accepts the presented byte this cycle |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Output word, lane k in bits 8k+7:8k |
| out_last | output | 1 | Output word is the last of its packet |
| out_end_lane | output | 2 | Lane of the last byte on a final word, else 0 |
| out_ready | input | 1 | Consumer takes the output word this cycle |

## Verification
The checker watches several rules on every cycle: the output is held while stalled, input is refused whenever the output slot is blocked, and the end lane is zero on non-final words. It also checks that lanes above the end lane are zero on a final word, and that the output is idle after reset. Lane order, alignment of back-to-back packets, and the absence of lost or duplicated bytes depend on whole packet histories. Only the bench shows these, by comparing each emitted word against words built from the bytes it sent, across packet lengths 1 to 9 and random stalls.

// File: rtl/packer_pkg.sv
package packer_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_LANES = 4;

  function automatic int lane_bits(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/packer_lane_ptr.sv
module packer_lane_ptr #(
  parameter int LANES = packer_pkg::NUM_LANES,
  localparam int PW = packer_pkg::lane_bits(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          take_last,
  output logic [PW-1:0] ptr,
  output logic          word_done
);
  localparam logic [PW-1:0] TOP_LANE = PW'(LANES - 1);

  logic at_top;
  assign at_top    = (ptr == TOP_LANE);
  assign word_done = take && (take_last || at_top);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (take) begin
      if (take_last || at_top) ptr <= '0;
      else                     ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/packer_assembler.sv
module packer_assembler #(
  parameter int DW    = packer_pkg::BYTE_W,
  parameter int LANES = packer_pkg::NUM_LANES,
  localparam int PW = packer_pkg::lane_bits(LANES),
  localparam int WW = DW * LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          word_done,
  input  logic [PW-1:0] ptr,
  input  logic [DW-1:0] byte_in,
  output logic [WW-1:0] merged
);
  logic [DW-1:0] held [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit;
    assign hit = (ptr == PW'(l));
    assign merged[l*DW +: DW] = hit ? byte_in : held[l];

    always_ff @(posedge clk) begin
      if (rst) begin
        held[l] <= '0;
      end else if (take) begin
        if (word_done) held[l] <= '0;
        else if (hit)  held[l] <= byte_in;
      end
    end
  end
endmodule

// File: rtl/packer_out_slot.sv
module packer_out_slot #(
  parameter int WW = packer_pkg::BYTE_W * packer_pkg::NUM_LANES,
  parameter int PW = packer_pkg::lane_bits(packer_pkg::NUM_LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [WW-1:0] load_data,
  input  logic          load_last,
  input  logic [PW-1:0] load_lane,
  input  logic          rdy,
  output logic          slot_free,
  output logic          vld,
  output logic [WW-1:0] data,
  output logic          last,
  output logic [PW-1:0] end_lane
);
  assign slot_free = !vld || rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= 1'b0;
      data     <= '0;
      last     <= 1'b0;
      end_lane <= '0;
    end else if (load) begin
      vld      <= 1'b1;
      data     <= load_data;
      last     <= load_last;
      end_lane <= load_last ? load_lane : '0;
    end else if (rdy) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int DW    = packer_pkg::BYTE_W,
  parameter int LANES = packer_pkg::NUM_LANES,
  localparam int PW = packer_pkg::lane_bits(LANES),
  localparam int WW = DW * LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          out_valid,
  output logic [WW-1:0] out_data,
  output logic          out_last,
  output logic [PW-1:0] out_end_lane,
  input  logic          out_ready
);
  logic          take;
  logic          word_done;
  logic [PW-1:0] ptr;
  logic [WW-1:0] merged;
  logic          slot_free;

  assign in_ready = slot_free;
  assign take     = in_valid && slot_free;

  packer_lane_ptr #(.LANES(LANES)) u_ptr (
    .clk(clk), .rst(rst), .take(take), .take_last(in_last),
    .ptr(ptr), .word_done(word_done)
  );

  packer_assembler #(.DW(DW), .LANES(LANES)) u_asm (
    .clk(clk), .rst(rst), .take(take), .word_done(word_done),
    .ptr(ptr), .byte_in(in_data), .merged(merged)
  );

  packer_out_slot #(.WW(WW), .PW(PW)) u_out (
    .clk(clk), .rst(rst), .load(word_done), .load_data(merged),
    .load_last(in_last), .load_lane(ptr), .rdy(out_ready),
    .slot_free(slot_free), .vld(out_valid), .data(out_data),
    .last(out_last), .end_lane(out_end_lane)
  );
endmodule

// File: rtl/byte_word_packer_checker.sv
module byte_word_packer_checker #(
  parameter int DW    = 8,
  parameter int LANES = 4,
  localparam int PW = packer_pkg::lane_bits(LANES),
  localparam int WW = DW * LANES
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic [WW-1:0] out_data,
  input logic          out_last,
  input logic [PW-1:0] out_end_lane,
  input logic          out_ready
);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_end_lane)));

  assert_refuse_when_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_accept_when_free_R9: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready);

  assert_mid_word_no_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_end_lane == '0));

  for (genvar l = 1; l < LANES; l++) begin : g_pad
    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_last && (int'(out_end_lane) < l)) |-> (out_data[l*DW +: DW] == '0));
  end
endmodule

bind byte_word_packer byte_word_packer_checker #(.DW(DW), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .out_end_lane(out_end_lane),
  .out_ready(out_ready)
);

// File: tb/byte_word_packer_test.sv
module byte_word_packer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_last;
  logic [1:0]  out_end_lane;
  logic        out_ready = 1'b1;

  always #4 clk = ~clk;

  byte_word_packer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_end_lane(out_end_lane),
    .out_ready(out_ready)
  );

  int vectors = 0;
  int errors  = 0;

  logic [7:0]  src_byte [$];
  logic        src_last [$];
  logic [31:0] exp_word [$];
  logic        exp_last [$];
  int          exp_lane [$];

  int ready_pct = 100;
  int gap_pct   = 0;
  int cycles    = 0;

  logic        stalled = 1'b0;
  logic [31:0] hold_data;
  logic        hold_last;
  logic [1:0]  hold_lane;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Build the bytes of a packet and the words a correct packer must give.
  task automatic plan_packet(input int len);
    logic [31:0] w = '0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'($urandom);
      src_byte.push_back(b);
      src_last.push_back(i == len - 1);
      w[(i % 4)*8 +: 8] = b;
      if (i % 4 == 3 || i == len - 1) begin
        exp_word.push_back(w);
        exp_last.push_back(i == len - 1);
        exp_lane.push_back((i == len - 1) ? (i % 4) : 0);
        w = '0;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (stalled) begin
      check(out_valid && out_data == hold_data && out_last == hold_last &&
            out_end_lane == hold_lane, "R8", "held word",
            {31'b0, out_valid, out_data}, {31'b0, 1'b1, hold_data});
    end
    out_ready = ($urandom_range(99) < ready_pct);
    if (src_byte.size() > 0 && $urandom_range(99) >= gap_pct) begin
      in_valid = 1'b1;
      in_data  = src_byte[0];
      in_last  = src_last[0];
    end else begin
      in_valid = 1'b0;
      in_data  = 8'($urandom);
      in_last  = 1'($urandom);
    end
    #1;
    check(in_ready == !(out_valid && !out_ready), "R9", "in_ready",
          64'(in_ready), 64'(!(out_valid && !out_ready)));
    if (out_valid && out_ready) begin
      if (exp_word.size() == 0) begin
        check(1'b0, "R9", "unexpected word", 64'(out_data), 64'hx);
      end else begin
        logic [31:0] ew = exp_word.pop_front();
        logic        el = exp_last.pop_front();
        int          en = exp_lane.pop_front();
        check(out_data[7:0] == ew[7:0], "R2", "lane0", 64'(out_data), 64'(ew));
        check(out_data == ew, el ? "R4" : "R3", "word", 64'(out_data), 64'(ew));
        check(out_last == el && int'(out_end_lane) == en, "R5", "last/end lane",
              {out_last, 32'(out_end_lane)}, {el, 32'(en)});
      end
    end
    if (in_valid && in_ready) begin
      void'(src_byte.pop_front());
      void'(src_last.pop_front());
    end
    stalled   = out_valid && !out_ready;
    hold_data = out_data;
    hold_last = out_last;
    hold_lane = out_end_lane;
  endtask

  task automatic drain();
    int guard = 0;
    while ((src_byte.size() > 0 || exp_word.size() > 0) && guard < 5000) begin
      step();
      guard++;
    end
    check(exp_word.size() == 0, "R9", "words outstanding",
          64'(exp_word.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R1", "reset state",
          {out_valid, in_ready}, 64'b01);
    @(negedge clk);
    rst = 1'b0;

    // R6: lone one-byte packet
    plan_packet(1);
    drain();
    // R7: lengths 1..9 back to back, no gaps, consumer always ready
    for (int n = 1; n <= 9; n++) plan_packet(n);
    drain();
    // R8/R9: stalls and input gaps
    ready_pct = 40;
    gap_pct   = 30;
    for (int k = 0; k < 150; k++) plan_packet($urandom_range(1, 11));
    drain();
    // R7: dense input, slow consumer
    ready_pct = 60;
    gap_pct   = 0;
    for (int k = 0; k < 150; k++) plan_packet($urandom_range(1, 6));
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule